// File: doc/BRIEF.md
# Dual-Channel Fixed-LO Digital Mixer

This block runs at the converter sample rate and mixes two 14-bit signed sample streams with a local oscillator. The oscillator frequency is one half, one quarter or one eighth of the sample rate. Because of that restriction the oscillator is a short repeating sequence of coefficient codes, not a phase accumulator. The coefficients are unity, zero or ±√2/2, so unit products become wiring and negation, and only the eighth-rate case uses a constant multiplier.

The block has three channel modes:
- **Bypass.** Samples pass through unmixed.
- **Real.** Each channel is mixed by the cosine sequence on its own.
- **Complex.** The two channels act as I and Q, and the outputs form a quadrature pair that can feed an external analog quadrature modulator for image-reject transmission.

A zero-stuffing option replaces every second sample slot with zero. This lifts high-frequency content against the converter's sin(x)/x roll-off. The source is expected to offer data only in the even slots. The oscillator phase restarts on a synchronous sync pulse or on any configuration change, so the phase relation between the outputs and the input stream is known.

Top module: `quad_mixer`

## Requirements
- R1: With `mode` = 0 (bypass), `out_a` and `out_b` equal `a_data` and `b_data` unchanged.
- R2: Every output is produced exactly 2 clock cycles after its input sample is presented, in every mode.
- R3: With `mode` = 1 (real) and `lo_sel` = 0 (half rate), each channel is multiplied by +1 on even phases and −1 on odd phases.
- R4: With `mode` = 1 and `lo_sel` = 1 (quarter rate), each channel is multiplied by the cosine sequence 1, 0, −1, 0 over phases 0..3.
- R5: With `lo_sel` = 2 or 3 (eighth rate), the cosine over phases 0..7 is 1, K, 0, −K, −1, −K, 0, K, where K = 11585/16384. Each result is (sum of products + 8192) shifted arithmetically right by 14.
- R6: With `mode` = 2 or 3 (complex), `out_a` = I·cos − Q·sin and `out_b` = I·sin + Q·cos, where I = `a_data` and Q = `b_data`. The sine is 0 at half rate, the sequence 0, 1, 0, −1 at quarter rate, and the sequence 0, K, 1, K, 0, −K, −1, −K at eighth rate.
- R7: A sample presented with `sync` high uses phase 0, and the following samples use phases 1, 2, and so on, modulo 8.
- R8: The first sample presented after any change of `{mode, lo_sel, zstuff}` uses phase 0.
- R9: With `zstuff` high, samples at odd phases give zero on both outputs, whatever data is presented in those slots.
- R10: A channel whose valid input is low contributes a zero sample.
- R11: Results outside the range −8192..8191 saturate to the nearer limit.
- R12: While `rst_n` is low, both outputs are zero and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low reset |
| sync | input | 1 | Restart the oscillator phase at this sample |
| mode | input | 2 | 0 bypass, 1 real, 2/3 complex |
| lo_sel | input | 2 | 0 half rate, 1 quarter rate, 2/3 eighth rate |
| zstuff | input | 1 | Zero-stuffing enable |
| a_valid | input | 1 | Channel A sample qualifier |
| a_data | input | 14 | Channel A sample (I), signed |
| b_valid | input | 1 | Channel B sample qualifier |
| b_data | input | 14 | Channel B sample (Q), signed |
| out_a | output | 14 | Mixed output A, signed |
| out_b | output | 14 | Mixed output B, signed |

## Verification
The bench tests each mode with different input patterns:
- **Uncorrelated ramp-like values on the two channels.** A swapped channel or a wrong sign on the sine term shows up at once.
- **Full-scale values, including −8192 on odd half-rate phases and equal maxima in complex eighth-rate mode.** These separate saturating arithmetic from wrapping arithmetic.
- **Long runs across phase wrap.** These expose a wrong entry in any coefficient table.
- **A sync pulse in mid-stream and a configuration change without sync.** These tell a correct phase restart from a free-running counter.
- **Data presented in stuffing slots and with valid low.** These show that such input is really discarded.

// File: rtl/quad_mixer.sv
module quad_mixer #(
  parameter int DW = 14,
  parameter int FB = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic [1:0]           mode,
  input  logic [1:0]           lo_sel,
  input  logic                 zstuff,
  input  logic                 a_valid,
  input  logic signed [DW-1:0] a_data,
  input  logic                 b_valid,
  input  logic signed [DW-1:0] b_data,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);

  localparam int PW   = DW + FB + 2;
  localparam int KQ   = $rtoi(0.7071067811865476 * (2.0 ** FB) + 0.5);
  localparam int MAXI = (1 << (DW - 1)) - 1;
  localparam logic signed [PW-1:0] KS   = PW'(KQ);
  localparam logic signed [PW-1:0] MAXV = PW'(MAXI);
  localparam logic signed [PW-1:0] MINV = PW'(-MAXI - 1);
  localparam logic signed [PW-1:0] HALF = PW'(1 << (FB - 1));

  localparam logic [2:0] C0 = 3'd0, CP1 = 3'd1, CN1 = 3'd2, CPK = 3'd3, CNK = 3'd4;

  function automatic logic [2:0] negc(input logic [2:0] c);
    case (c)
      CP1:     negc = CN1;
      CN1:     negc = CP1;
      CPK:     negc = CNK;
      CNK:     negc = CPK;
      default: negc = C0;
    endcase
  endfunction

  function automatic logic [2:0] cosc(input logic [1:0] lo, input logic [2:0] p);
    if (lo == 2'd0) cosc = p[0] ? CN1 : CP1;
    else if (lo == 2'd1) begin
      case (p[1:0])
        2'd0:    cosc = CP1;
        2'd2:    cosc = CN1;
        default: cosc = C0;
      endcase
    end else begin
      case (p)
        3'd0:    cosc = CP1;
        3'd1:    cosc = CPK;
        3'd3:    cosc = CNK;
        3'd4:    cosc = CN1;
        3'd5:    cosc = CNK;
        3'd7:    cosc = CPK;
        default: cosc = C0;
      endcase
    end
  endfunction

  function automatic logic [2:0] sinc(input logic [1:0] lo, input logic [2:0] p);
    if (lo == 2'd0) sinc = C0;
    else if (lo == 2'd1) begin
      case (p[1:0])
        2'd1:    sinc = CP1;
        2'd3:    sinc = CN1;
        default: sinc = C0;
      endcase
    end else begin
      case (p)
        3'd1:    sinc = CPK;
        3'd2:    sinc = CP1;
        3'd3:    sinc = CPK;
        3'd5:    sinc = CNK;
        3'd6:    sinc = CN1;
        3'd7:    sinc = CNK;
        default: sinc = C0;
      endcase
    end
  endfunction

  function automatic logic signed [PW-1:0] mulc(input logic signed [DW-1:0] x, input logic [2:0] c);
    logic signed [PW-1:0] xe;
    xe = PW'(x);
    case (c)
      CP1:     mulc = xe <<< FB;
      CN1:     mulc = -(xe <<< FB);
      CPK:     mulc = xe * KS;
      CNK:     mulc = -(xe * KS);
      default: mulc = '0;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] mix(input logic signed [DW-1:0] x, input logic signed [DW-1:0] y,
                                               input logic [2:0] cx, input logic [2:0] cy);
    logic signed [PW-1:0] s;
    s = (mulc(x, cx) + mulc(y, cy) + HALF) >>> FB;
    if (s > MAXV)      mix = MAXV[DW-1:0];
    else if (s < MINV) mix = MINV[DW-1:0];
    else               mix = s[DW-1:0];
  endfunction

  logic [4:0] cfg, cfg_q;
  logic [2:0] ph, p, c_cos, c_sin;
  logic       stuff, s_stuff;
  logic [2:0] k1, k2, k3, k4, s_k1, s_k2, s_k3, s_k4;
  logic signed [DW-1:0] ia, ib, s_a, s_b;

  assign cfg   = {mode, lo_sel, zstuff};
  assign p     = (sync || cfg != cfg_q) ? 3'd0 : ph;
  assign stuff = zstuff && p[0];
  assign ia    = (a_valid && !stuff) ? a_data : '0;
  assign ib    = (b_valid && !stuff) ? b_data : '0;
  assign c_cos = cosc(lo_sel, p);
  assign c_sin = sinc(lo_sel, p);

  always_comb begin
    case (mode)
      2'd0:    begin k1 = CP1;   k2 = C0;          k3 = C0;    k4 = CP1;   end
      2'd1:    begin k1 = c_cos; k2 = C0;          k3 = C0;    k4 = c_cos; end
      default: begin k1 = c_cos; k2 = negc(c_sin); k3 = c_sin; k4 = c_cos; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; cfg_q <= '0; s_stuff <= 1'b0;
      s_a <= '0; s_b <= '0;
      s_k1 <= C0; s_k2 <= C0; s_k3 <= C0; s_k4 <= C0;
      out_a <= '0; out_b <= '0;
    end else begin
      ph <= 3'(p + 3'd1);
      cfg_q <= cfg;
      s_stuff <= stuff;
      s_a <= ia; s_b <= ib;
      s_k1 <= k1; s_k2 <= k2; s_k3 <= k3; s_k4 <= k4;
      out_a <= mix(s_a, s_b, s_k1, s_k2);
      out_b <= mix(s_a, s_b, s_k3, s_k4);
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r1_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(mode, 2) == 2'd0 && !$past(zstuff, 2) && $past(a_valid, 2))
      |-> out_a == $past(a_data, 2));

  a_r10_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(mode, 2) == 2'd0 && !$past(a_valid, 2)) |-> out_a == '0);

  a_r3_sync_unit_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(mode, 2) == 2'd1 && $past(lo_sel, 2) == 2'd0 && $past(sync, 2)
     && !$past(zstuff, 2) && $past(a_valid, 2)) |-> out_a == $past(a_data, 2));

  a_r9_stuff_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    s_stuff |=> (out_a == '0 && out_b == '0));

  a_r7_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> ph == 3'd1);

  a_r8_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != cfg_q) |=> ph == 3'd1);

endmodule

// File: tb/quad_mixer_test.sv
module quad_mixer_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  logic rst_n, sync, zstuff, a_valid, b_valid;
  logic [1:0] mode, lo_sel;
  logic signed [13:0] a_data, b_data, out_a, out_b;

  quad_mixer uut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .mode(mode), .lo_sel(lo_sel), .zstuff(zstuff),
    .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
    .out_a(out_a), .out_b(out_b)
  );

  typedef struct { int ea; int eb; int due; string tag; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  int ph_m = 0;
  logic [4:0] prev_cfg = '0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  localparam int ONE = 16384, K = 11585;

  function automatic int cosv(int lo, int p);
    if (lo == 0) return (p % 2) ? -ONE : ONE;
    if (lo == 1) begin
      case (p % 4) 0: return ONE; 2: return -ONE; default: return 0; endcase
    end
    case (p) 0: return ONE; 1: return K; 3: return -K; 4: return -ONE;
             5: return -K; 7: return K; default: return 0; endcase
  endfunction

  function automatic int sinv(int lo, int p);
    if (lo == 0) return 0;
    if (lo == 1) begin
      case (p % 4) 1: return ONE; 3: return -ONE; default: return 0; endcase
    end
    case (p) 1: return K; 2: return ONE; 3: return K; 5: return -K;
             6: return -ONE; 7: return -K; default: return 0; endcase
  endfunction

  function automatic int mixv(int x, int y, int cx, int cy);
    longint s;
    s = (longint'(x) * cx + longint'(y) * cy + 8192) >>> 14;
    if (s > 8191) return 8191;
    if (s < -8192) return -8192;
    return int'(s);
  endfunction

  function automatic int pat(int i, int k);
    return ((i * 2741 + k * 977 + 311) % 16384) - 8192;
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step(int a, int b, bit va, bit vb, bit sy, string tag);
    int p, ia, ib, c, s, lo;
    bit st;
    logic [4:0] cfg;
    item_t it;
    a_data = 14'(a); b_data = 14'(b); a_valid = va; b_valid = vb; sync = sy;
    cfg = {mode, lo_sel, zstuff};
    p = (sy || cfg != prev_cfg) ? 0 : ph_m;
    ph_m = (p + 1) % 8;
    prev_cfg = cfg;
    st = zstuff && (p % 2 == 1);
    ia = (va && !st) ? a : 0;
    ib = (vb && !st) ? b : 0;
    lo = int'(lo_sel);
    c = cosv(lo, p); s = sinv(lo, p);
    if (mode == 2'd0)      begin it.ea = mixv(ia, ib, ONE, 0); it.eb = mixv(ia, ib, 0, ONE); end
    else if (mode == 2'd1) begin it.ea = mixv(ia, ib, c, 0);   it.eb = mixv(ia, ib, 0, c);   end
    else                   begin it.ea = mixv(ia, ib, c, -s);  it.eb = mixv(ia, ib, s, c);   end
    it.due = cyc + 2;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.due != cyc || int'(out_a) != it.ea || int'(out_b) != it.eb) begin
        errors++;
        $display("FAIL %s: out_a=%0d out_b=%0d expected %0d %0d (cycle %0d)",
                 it.tag, out_a, out_b, it.ea, it.eb, cyc);
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; sync = 0; zstuff = 0; a_valid = 0; b_valid = 0;
    mode = 0; lo_sel = 0; a_data = 0; b_data = 0;
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (out_a !== 14'sd0 || out_b !== 14'sd0) begin
      errors++;
      $display("FAIL R12: out_a=%0d out_b=%0d expected 0 0", out_a, out_b);
    end
    rst_n = 1;

    // R1 R2 bypass, R10 invalid lanes
    for (int i = 0; i < 6; i++) step(pat(i, 0), pat(i, 5), 1, 1, 0, "R1 R2");
    step(1234, -55, 0, 1, 0, "R10");
    step(-77, 4000, 1, 0, 0, "R10");

    // R3 half-rate real, R11 on odd phase with -8192
    mode = 1; lo_sel = 0;
    step(1000, -2000, 1, 1, 1, "R3 R7");
    step(1000, -2000, 1, 1, 0, "R3");
    step(300, 8191, 1, 1, 0, "R3");
    step(-8192, -8192, 1, 1, 0, "R3 R11");
    for (int i = 0; i < 4; i++) step(pat(i, 1), pat(i, 2), 1, 1, 0, "R3");

    // R4 quarter-rate real
    lo_sel = 1;
    for (int i = 0; i < 8; i++) step(pat(i, 3), pat(i, 4), 1, 1, 0, "R4 R8");

    // R5 eighth-rate real
    lo_sel = 2;
    for (int i = 0; i < 10; i++) step(pat(i, 6), pat(i, 7), 1, 1, 0, "R5");
    for (int i = 0; i < 4; i++) step(8191, -8192, 1, 1, 0, "R5 R11");
    step(1, -1, 1, 1, 0, "R5");
    step(3, -3, 1, 1, 0, "R5");

    // R6 complex, quarter then eighth rate
    mode = 2; lo_sel = 1;
    for (int i = 0; i < 8; i++) step(pat(i, 8), pat(i, 9), 1, 1, 0, "R6");
    lo_sel = 3;
    for (int i = 0; i < 16; i++) step(pat(i, 10), pat(i, 11), 1, 1, 0, "R6");
    for (int i = 0; i < 8; i++) step(8191, 8191, 1, 1, 0, "R6 R11");
    for (int i = 0; i < 8; i++) step(-8192, 8191, 1, 1, 0, "R6 R11");

    // R7 mid-stream sync
    for (int i = 0; i < 6; i++) step(pat(i, 12), pat(i, 13), 1, 1, (i == 3), "R7");

    // R8 configuration change without sync
    mode = 1; lo_sel = 2;
    for (int i = 0; i < 3; i++) step(pat(i, 14), 500, 1, 1, 0, "R8");
    lo_sel = 1;
    for (int i = 0; i < 5; i++) step(pat(i, 15), -500, 1, 1, 0, "R8");

    // R9 zero stuffing in real and bypass modes
    zstuff = 1;
    for (int i = 0; i < 8; i++) step(pat(i, 16), pat(i, 17), 1, 1, 0, "R9");
    mode = 0;
    for (int i = 0; i < 6; i++) step(7000, -7000, 1, 1, 0, "R9");

    zstuff = 0; mode = 2; lo_sel = 0;
    for (int i = 0; i < 4; i++) step(pat(i, 18), pat(i, 19), 1, 1, 0, "R6");

    a_valid = 0; b_valid = 0;
    repeat (4) @(negedge clk);
    #2;
    finish_up();
  end
endmodule